// File: doc/BRIEF.md
# Sessionless Power-Aware Self-Test Dispatcher

This controller starts and tracks the built-in tests of a group of cores without grouping them into sessions. Each core can carry up to two test runs: an internal self-test and, after it, an external deterministic test. A pending run is launched once three things hold. The power weights of the running tests plus its own weight stay within a budget. No running test shares a test resource with it. Every core it must wait for has completed all of its runs. When a run finishes, either because its cycle budget runs out or because the core signals done, the freed power and resources are used in the next cycle.

Configuration is presented on static ports and captured when `start` pulses. These ports carry per-core durations for both runs, a per-core power weight, a symmetric conflict matrix, per-core precedence masks and the power limit. A `start` pulse clears all state and begins a new schedule. The block reports a per-core start pulse, which run that pulse began, cores that can never be scheduled, a global completion flag and the total elapsed cycle count.

Top module: `sessionless_test_dispatcher`

## Requirements
- R1: A cycle with `start` high clears all schedule state. In the following cycle `core_start` is all zero, `all_done` is 0 and `elapsed` is 0. After reset, all three outputs are zero.
- R2: In every cycle, the summed power weights of all running runs do not exceed `pmax`.
- R3: Two cores whose conflict bit is set (bit `i*N+j` of `cfg_conflict`) are never running in the same cycle.
- R4: At most one run is launched per clock. A pending run is launched at the first clock edge at which it is eligible and no other eligible run outranks it. The start pulse on `core_start[i]` appears in the cycle after that edge.
- R5: Among eligible pending runs, the one with the largest configured duration for that run wins. On a tie in duration, the lowest core index wins.
- R6: Core i launches no run while any core j with bit `i*N+j` of `cfg_prec` set has unfinished runs.
- R7: A core's self-test (`cfg_dur_self`) always runs before its external test (`cfg_dur_ext`), and the two never overlap. A run with duration 0 is skipped. `core_ext[i]` is 0 for a self-test start and 1 for an external start.
- R8: A run lasts exactly its configured number of cycles, counted from its start-pulse cycle. It ends earlier if `core_done[i]` is high in one of those cycles, and that cycle is then its last. A `core_done` pulse on a core that is not running has no effect.
- R9: A core whose power weight exceeds `pmax` is flagged in `unsched` from the cycle after `start`, is never started, and counts as finished.
- R10: `elapsed` increments once per cycle while any core has unfinished runs. `all_done` rises one cycle after the last run ends and holds until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clear state and begin a schedule |
| cfg_dur_self | input | N_CORES*DUR_W | Self-test cycle count per core |
| cfg_dur_ext | input | N_CORES*DUR_W | External test cycle count per core |
| cfg_pwr | input | N_CORES*PWR_W | Power weight per core |
| cfg_conflict | input | N_CORES*N_CORES | Symmetric resource conflict matrix |
| cfg_prec | input | N_CORES*N_CORES | Row i: cores that must finish before core i |
| pmax | input | SUM_W | Power budget |
| core_done | input | N_CORES | Early-completion pulses from the cores |
| core_start | output | N_CORES | Start pulse per core |
| core_ext | output | N_CORES | Run type of the latest start (1 = external) |
| unsched | output | N_CORES | Core power weight exceeds the budget |
| all_done | output | 1 | Every configured run has completed |
| elapsed | output | CYC_W | Cycles spent with work outstanding |

## Verification
The hardest situation to reach is a clock edge at which several runs are individually eligible but cannot all fit. Only a correct one-per-edge choice then keeps the power budget and the conflict matrix intact. Random configurations use tight budgets, dense conflicts and acyclic precedence masks, together with random early `core_done` pulses. These pulses free capacity at unpredictable moments, so many pending runs compete on the same edge. A cycle-level reference model is compared every cycle. A separate tracker, driven only by the observed start pulses, checks power, conflicts, precedence and run order.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  typedef enum logic [2:0] {
    ST_PEND_SELF = 3'd0,
    ST_RUN_SELF  = 3'd1,
    ST_PEND_EXT  = 3'd2,
    ST_RUN_EXT   = 3'd3,
    ST_FIN       = 3'd4
  } slot_st_t;
endpackage

// File: rtl/tsd_slot.sv
module tsd_slot
  import tsd_pkg::*;
#(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             skip,
  input  logic [DUR_W-1:0] dur_self,
  input  logic [DUR_W-1:0] dur_ext,
  input  logic             launch,
  input  logic             done_in,
  output slot_st_t         st,
  output logic [DUR_W-1:0] pend_dur
);
  localparam logic [DUR_W-1:0] ONE = {{(DUR_W-1){1'b0}}, 1'b1};
  logic [DUR_W-1:0] cnt;
  logic             run_end;

  assign pend_dur = (st == ST_PEND_SELF) ? dur_self : dur_ext;
  assign run_end  = (cnt == ONE) || done_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_FIN;
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
      if (skip)                 st <= ST_FIN;
      else if (dur_self != '0)  st <= ST_PEND_SELF;
      else if (dur_ext != '0)   st <= ST_PEND_EXT;
      else                      st <= ST_FIN;
    end else begin
      case (st)
        ST_PEND_SELF: if (launch) begin st <= ST_RUN_SELF; cnt <= dur_self; end
        ST_PEND_EXT:  if (launch) begin st <= ST_RUN_EXT;  cnt <= dur_ext;  end
        ST_RUN_SELF: begin
          if (run_end) st <= (dur_ext != '0) ? ST_PEND_EXT : ST_FIN;
          else         cnt <= cnt - ONE;
        end
        ST_RUN_EXT: begin
          if (run_end) st <= ST_FIN;
          else         cnt <= cnt - ONE;
        end
        default: st <= ST_FIN;
      endcase
    end
  end

  always_comb begin
    if (!rst && launch)
      assert_launch_pending_R4: assert (st == ST_PEND_SELF || st == ST_PEND_EXT)
        else $error("launch on non-pending slot");
  end

  assert_run_order_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN_EXT) |-> ($past(st) == ST_PEND_EXT || $past(st) == ST_RUN_EXT))
    else $error("external run without prior pending state");

  assert_run_length_R8: assert property (@(posedge clk) disable iff (rst || clear)
    (st == ST_RUN_SELF && cnt > ONE && !done_in) |=> (st == ST_RUN_SELF))
    else $error("self-test ended early");
endmodule

// File: rtl/tsd_pick.sv
module tsd_pick #(
  parameter int N_CORES = 4,
  parameter int DUR_W   = 16,
  parameter int PWR_W   = 8,
  parameter int SUM_W   = 11
) (
  input  logic [N_CORES-1:0]         pend,
  input  logic [N_CORES-1:0]         run,
  input  logic [N_CORES-1:0]         fin,
  input  logic [N_CORES*DUR_W-1:0]   pend_dur,
  input  logic [N_CORES*PWR_W-1:0]   pwr,
  input  logic [N_CORES*N_CORES-1:0] conflict,
  input  logic [N_CORES*N_CORES-1:0] prec,
  input  logic [SUM_W-1:0]           pmax,
  output logic [N_CORES-1:0]         launch,
  output logic [SUM_W-1:0]           run_pwr
);
  localparam int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  logic             found;
  logic [IDX_W-1:0] best;
  logic [DUR_W-1:0] best_dur;
  logic             elig;
  logic [SUM_W-1:0] w;

  always_comb begin
    run_pwr = '0;
    for (int i = 0; i < N_CORES; i++)
      if (run[i]) run_pwr = run_pwr + SUM_W'(pwr[i*PWR_W +: PWR_W]);
    found    = 1'b0;
    best     = '0;
    best_dur = '0;
    for (int i = 0; i < N_CORES; i++) begin
      w    = SUM_W'(pwr[i*PWR_W +: PWR_W]);
      elig = pend[i] && (run_pwr + w <= pmax)
             && ((conflict[i*N_CORES +: N_CORES] & run) == '0)
             && ((prec[i*N_CORES +: N_CORES] & ~fin) == '0);
      if (elig && (!found || pend_dur[i*DUR_W +: DUR_W] > best_dur)) begin
        found    = 1'b1;
        best     = IDX_W'(i);
        best_dur = pend_dur[i*DUR_W +: DUR_W];
      end
    end
    launch = '0;
    if (found) launch[best] = 1'b1;
  end
endmodule

// File: rtl/sessionless_test_dispatcher.sv
module sessionless_test_dispatcher
  import tsd_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int DUR_W   = 16,
  parameter int PWR_W   = 8,
  parameter int CYC_W   = 32,
  parameter int SUM_W   = PWR_W + $clog2(N_CORES) + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [N_CORES*DUR_W-1:0]   cfg_dur_self,
  input  logic [N_CORES*DUR_W-1:0]   cfg_dur_ext,
  input  logic [N_CORES*PWR_W-1:0]   cfg_pwr,
  input  logic [N_CORES*N_CORES-1:0] cfg_conflict,
  input  logic [N_CORES*N_CORES-1:0] cfg_prec,
  input  logic [SUM_W-1:0]           pmax,
  input  logic [N_CORES-1:0]         core_done,
  output logic [N_CORES-1:0]         core_start,
  output logic [N_CORES-1:0]         core_ext,
  output logic [N_CORES-1:0]         unsched,
  output logic                       all_done,
  output logic [CYC_W-1:0]           elapsed
);
  slot_st_t             st [N_CORES];
  logic [N_CORES*DUR_W-1:0] pend_dur;
  logic [N_CORES-1:0]   pend, run, fin, over_lim, launch;
  logic [SUM_W-1:0]     run_pwr;
  logic                 busy;

  for (genvar g = 0; g < N_CORES; g++) begin : g_slot
    assign over_lim[g] = SUM_W'(cfg_pwr[g*PWR_W +: PWR_W]) > pmax;
    tsd_slot #(.DUR_W(DUR_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .clear    (start),
      .skip     (over_lim[g]),
      .dur_self (cfg_dur_self[g*DUR_W +: DUR_W]),
      .dur_ext  (cfg_dur_ext[g*DUR_W +: DUR_W]),
      .launch   (launch[g]),
      .done_in  (core_done[g]),
      .st       (st[g]),
      .pend_dur (pend_dur[g*DUR_W +: DUR_W])
    );
    assign pend[g] = (st[g] == ST_PEND_SELF) || (st[g] == ST_PEND_EXT);
    assign run[g]  = (st[g] == ST_RUN_SELF)  || (st[g] == ST_RUN_EXT);
    assign fin[g]  = (st[g] == ST_FIN);
  end

  tsd_pick #(.N_CORES(N_CORES), .DUR_W(DUR_W), .PWR_W(PWR_W), .SUM_W(SUM_W)) u_pick (
    .pend     (pend),
    .run      (run),
    .fin      (fin),
    .pend_dur (pend_dur),
    .pwr      (cfg_pwr),
    .conflict (cfg_conflict),
    .prec     (cfg_prec),
    .pmax     (pmax),
    .launch   (launch),
    .run_pwr  (run_pwr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      core_start <= '0;
      core_ext   <= '0;
      unsched    <= '0;
      all_done   <= 1'b0;
      elapsed    <= '0;
    end else if (start) begin
      busy       <= 1'b1;
      core_start <= '0;
      core_ext   <= '0;
      unsched    <= over_lim;
      all_done   <= 1'b0;
      elapsed    <= '0;
    end else begin
      core_start <= launch;
      for (int i = 0; i < N_CORES; i++)
        if (launch[i]) core_ext[i] <= (st[i] == ST_PEND_EXT);
      all_done <= busy && (&fin);
      if (busy && !(&fin)) elapsed <= elapsed + 1'b1;
    end
  end

  assert_power_budget_R2: assert property (@(posedge clk) disable iff (rst || start)
    busy |-> (run_pwr <= pmax))
    else $error("power budget exceeded");

  for (genvar a = 0; a < N_CORES; a++) begin : g_chk_a
    for (genvar b = a + 1; b < N_CORES; b++) begin : g_chk_b
      assert_no_conflict_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_conflict[a*N_CORES+b] |-> !(run[a] && run[b]))
        else $error("conflicting cores running together");
    end
    assert_never_start_unsched_R9: assert property (@(posedge clk) disable iff (rst || start)
      core_start[a] |-> !unsched[a])
      else $error("unschedulable core started");
    assert_prec_met_R6: assert property (@(posedge clk) disable iff (rst || start)
      core_start[a] |-> ((cfg_prec[a*N_CORES +: N_CORES] & ~fin) == '0))
      else $error("precedence violated");
  end

  assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (all_done && !start) |=> all_done)
    else $error("all_done dropped");
endmodule

// File: tb/test_sessionless_test_dispatcher.sv
module test_sessionless_test_dispatcher;
  localparam int N = 4, DW = 16, PW = 8, CW = 32, SW = 11;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst = 1, start = 0;
  logic [N*DW-1:0] cfg_da = '0, cfg_db = '0;
  logic [N*PW-1:0] cfg_pw = '0;
  logic [N*N-1:0]  cfg_cf = '0, cfg_pr = '0;
  logic [SW-1:0]   pmax = '0;
  logic [N-1:0]    core_done = '0;
  logic [N-1:0]    core_start, core_ext, unsched;
  logic            all_done;
  logic [CW-1:0]   elapsed;

  always #(CLK_PERIOD/2) clk = ~clk;

  sessionless_test_dispatcher #(.N_CORES(N), .DUR_W(DW), .PWR_W(PW), .CYC_W(CW), .SUM_W(SW)) i_sessionless_test_dispatcher (
    .clk(clk), .rst(rst), .start(start), .cfg_dur_self(cfg_da), .cfg_dur_ext(cfg_db),
    .cfg_pwr(cfg_pw), .cfg_conflict(cfg_cf), .cfg_prec(cfg_pr), .pmax(pmax),
    .core_done(core_done), .core_start(core_start), .core_ext(core_ext),
    .unsched(unsched), .all_done(all_done), .elapsed(elapsed));

  int n_chk = 0, n_bad = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int da(int i); return int'(cfg_da[i*DW +: DW]); endfunction
  function automatic int db(int i); return int'(cfg_db[i*DW +: DW]); endfunction
  function automatic int pw(int i); return int'(cfg_pw[i*PW +: PW]); endfunction
  function automatic bit cf(int i, int j); return cfg_cf[i*N+j]; endfunction
  function automatic bit pr(int i, int j); return cfg_pr[i*N+j]; endfunction
  function automatic bit over(int i); return pw(i) > int'(pmax); endfunction

  // reference model: 0 pend self,1 run self,2 pend ext,3 run ext,4 finished
  int m_st[N], m_cnt[N], m_elapsed = 0;
  logic [N-1:0] m_start = '0, m_ext = '0, m_uns = '0;
  bit m_busy = 0, m_alldone = 0, m_clr = 0;

  always @(posedge clk) begin
    m_clr = 0;
    if (rst) begin
      m_busy = 0; m_start = '0; m_ext = '0; m_uns = '0; m_alldone = 0; m_elapsed = 0;
      for (int i = 0; i < N; i++) begin m_st[i] = 4; m_cnt[i] = 0; end
    end else if (start) begin
      m_clr = 1; m_busy = 1; m_start = '0; m_ext = '0; m_alldone = 0; m_elapsed = 0;
      for (int i = 0; i < N; i++) begin
        m_uns[i] = over(i);
        m_st[i] = over(i) ? 4 : (da(i) != 0) ? 0 : (db(i) != 0) ? 2 : 4;
      end
    end else begin
      int sum, best, bd, d, old;
      bit allfin, ok;
      allfin = 1;
      for (int i = 0; i < N; i++) if (m_st[i] != 4) allfin = 0;
      if (m_busy && !allfin) m_elapsed++;
      m_alldone = m_busy && allfin;
      sum = 0;
      for (int i = 0; i < N; i++) if (m_st[i] == 1 || m_st[i] == 3) sum += pw(i);
      best = -1; bd = 0;
      for (int i = 0; i < N; i++) if (m_st[i] == 0 || m_st[i] == 2) begin
        d = (m_st[i] == 0) ? da(i) : db(i);
        ok = (sum + pw(i) <= int'(pmax));
        for (int j = 0; j < N; j++) begin
          if (cf(i, j) && (m_st[j] == 1 || m_st[j] == 3)) ok = 0;
          if (pr(i, j) && m_st[j] != 4) ok = 0;
        end
        if (ok && (best < 0 || d > bd)) begin best = i; bd = d; end
      end
      for (int i = 0; i < N; i++) if (m_st[i] == 1 || m_st[i] == 3) begin
        if (m_cnt[i] == 1 || core_done[i]) m_st[i] = (m_st[i] == 1 && db(i) != 0) ? 2 : 4;
        else m_cnt[i]--;
      end
      m_start = '0;
      if (best >= 0) begin
        old = m_st[best];
        m_start[best] = 1'b1;
        m_ext[best] = (old == 2);
        m_st[best] = (old == 0) ? 1 : 3;
        m_cnt[best] = bd;
      end
    end
  end

  // port-side tracker and per-cycle comparisons
  bit chk_en = 0, rnd_done = 0;
  bit o_act[N], o_ext[N], o_bdone[N], o_fin[N];
  int o_left[N];
  logic [N-1:0] prev_done = '0;

  always @(negedge clk) if (chk_en) begin
    int s;
    chk(core_start == m_start, "R4", "core_start vector", core_start, m_start);
    for (int i = 0; i < N; i++)
      if (core_start[i]) chk(core_ext[i] == m_ext[i], "R7", "run type of start", core_ext[i], m_ext[i]);
    chk(all_done == m_alldone, "R10", "all_done", all_done, m_alldone);
    chk(elapsed == CW'(m_elapsed), "R10", "elapsed", elapsed, m_elapsed);
    chk(unsched == m_uns, "R9", "unsched", unsched, m_uns);
    if (m_clr) begin
      for (int i = 0; i < N; i++) begin
        o_act[i] = 0; o_ext[i] = 0; o_bdone[i] = (da(i) == 0);
        o_fin[i] = over(i) || (da(i) == 0 && db(i) == 0);
      end
      chk(core_start == '0 && all_done == 0 && elapsed == 0, "R1", "outputs after start", {core_start, all_done}, 0);
    end else begin
      for (int i = 0; i < N; i++) if (o_act[i]) begin
        if (prev_done[i] || o_left[i] == 1) begin
          o_act[i] = 0;
          if (o_ext[i]) o_fin[i] = 1;
          else begin o_bdone[i] = 1; if (db(i) == 0) o_fin[i] = 1; end
        end else o_left[i]--;
      end
      for (int i = 0; i < N; i++) if (core_start[i]) begin
        chk(!over(i), "R9", "unschedulable core started", i, -1);
        for (int j = 0; j < N; j++)
          if (pr(i, j)) chk(o_fin[j], "R6", "start before predecessor finished", j, i);
        if (core_ext[i]) chk(o_bdone[i] && !o_act[i], "R7", "external before self-test", i, -1);
        o_act[i] = 1; o_ext[i] = core_ext[i];
        o_left[i] = core_ext[i] ? db(i) : da(i);
      end
      s = 0;
      for (int i = 0; i < N; i++) if (o_act[i]) s += pw(i);
      chk(s <= int'(pmax), "R2", "running power", s, int'(pmax));
      for (int i = 0; i < N; i++) for (int j = i + 1; j < N; j++)
        if (cf(i, j)) chk(!(o_act[i] && o_act[j]), "R3", "conflicting pair active", i*N+j, 0);
    end
    for (int i = 0; i < N; i++) core_done[i] = rnd_done && ($urandom % 40 == 0);
    prev_done = core_done;
  end

  task automatic run_case(int limit);
    int n;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    n = 0;
    while (!all_done && n < limit) begin @(negedge clk); n++; end
    chk(all_done == 1, "R10", "schedule completes", n, limit);
    repeat (3) @(negedge clk);
  endtask

  function automatic void set_core(int i, int a, int b, int p);
    cfg_da[i*DW +: DW] = DW'(a); cfg_db[i*DW +: DW] = DW'(b); cfg_pw[i*PW +: PW] = PW'(p);
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(core_start == '0 && all_done == 0 && elapsed == 0, "R1", "reset state", elapsed, 0);
    rst = 0;
    chk_en = 1;
    // R5: one at a time, durations 10,30,30,20 -> core1 first (tie with core3? no: core2 ties core1, lower wins)
    set_core(0, 10, 0, 10); set_core(1, 30, 0, 10); set_core(2, 30, 0, 10); set_core(3, 20, 0, 10);
    pmax = SW'(10); cfg_cf = '0; cfg_pr = '0;
    @(negedge clk); start = 1; @(negedge clk); start = 0; @(negedge clk);
    chk(core_start == 4'b0010, "R5", "longest eligible first, tie to lower index", core_start, 4'b0010);
    begin int n = 0; while (!all_done && n < 500) begin @(negedge clk); n++; end end
    // R6, R9, R7: precedence chain, unschedulable core, skipped runs
    set_core(0, 5, 7, 4); set_core(1, 0, 6, 4); set_core(2, 8, 0, 50); set_core(3, 0, 0, 4);
    pmax = SW'(12); cfg_pr = '0; cfg_pr[0*N+1] = 1'b1; cfg_pr[1*N+2] = 1'b1;
    run_case(500);
    chk(unsched == 4'b0100, "R9", "unsched flag held", unsched, 4'b0100);
    // R3 and R8: conflicts with early done pulses
    rnd_done = 1;
    set_core(0, 12, 4, 3); set_core(1, 9, 9, 3); set_core(2, 6, 0, 3); set_core(3, 15, 2, 3);
    pmax = SW'(40); cfg_pr = '0; cfg_cf = '0;
    cfg_cf[0*N+1] = 1; cfg_cf[1*N+0] = 1; cfg_cf[2*N+3] = 1; cfg_cf[3*N+2] = 1;
    run_case(500);
    // random schedules
    for (int t = 0; t < 40; t++) begin
      pmax = SW'(8 + $urandom % 25);
      cfg_cf = '0; cfg_pr = '0;
      for (int i = 0; i < N; i++) begin
        set_core(i, $urandom % 30, ($urandom % 3 == 0) ? 0 : $urandom % 25,
                 ($urandom % 10 == 0) ? 40 : 1 + $urandom % 15);
        for (int j = 0; j < i; j++) begin
          if ($urandom % 3 == 0) begin cfg_cf[i*N+j] = 1; cfg_cf[j*N+i] = 1; end
          if ($urandom % 5 == 0) cfg_pr[i*N+j] = 1;
        end
      end
      run_case(2000);
    end
    // R8 ignored done: pulse done on idle cores after completion
    rnd_done = 1; repeat (50) @(negedge clk);
    chk(all_done == 1 && core_start == '0, "R8", "idle done pulses ignored", core_start, 0);
    rnd_done = 0; chk_en = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule